// File: doc/BRIEF.md
# Byte-Loaded Colour Palette

This block is a 256-entry colour palette. A host loads it through two byte-wide write strobes: one writes an entry index, the other carries colour bytes. After an index write, three colour-byte writes in a row supply the red, green and blue channels of the selected entry. The entry is written as one 24-bit word only when the blue byte arrives. The index then steps to the next entry, so a whole palette can be streamed in after a single index write.

A pixel pipeline reads the palette through its own port. Each cycle it presents an 8-bit index and gets back the 24-bit colour one clock later. Both sides share one storage array with one write port and one read port. Neither side stalls the other.

Top module: `palLut`

## Requirements
- R1: While reset is held, pixRgb reads zero. Reset sets the write index to 0 and the channel sequencer to red, so colour bytes written after reset with no index write fill entry 0 onward.
- R2: A cycle with hostAddrWr high loads hostByte into the write index and returns the channel sequencer to red, even if an earlier entry is only partly loaded.
- R3: Successive colour-byte writes fill red, then green, then blue. pixRgb carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: An entry changes only when its blue byte is written. After only the red and green writes, a read of that entry still returns its previous value.
- R5: After each blue write, the write index steps up by one and wraps from 255 to 0. The sequencer returns to red.
- R6: The colour of entry pixIdx, as stored at a rising edge, appears on pixRgb after that edge and stays there until the next edge.
- R7: If a blue write and a pixel read hit the same entry in the same cycle, the read returns the value the entry held before the write. The next read returns the new value.
- R8: If hostAddrWr and hostDataWr are both high in one cycle, only the index write takes effect and the colour byte is discarded.
- R9: In a cycle with neither strobe high, the write index, the sequencer and the stored entries all keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both host and pixel sides |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddrWr | input | 1 | Index-write strobe; hostByte is the new entry index |
| hostDataWr | input | 1 | Colour-byte strobe; hostByte is the next channel value |
| hostByte | input | 8 | Host write data |
| pixIdx | input | 8 | Pixel-side palette index |
| pixRgb | output | 24 | Colour of the indexed entry, registered |

## Verification
The host commit of a blue byte and the pixel read can hit the same storage entry in the same cycle. The bench forces this in a directed case: on the blue write, the read index is set to the entry being written. The read result must still be the old colour, and the new colour must appear one cycle later. The random phase also keeps landing reads on entries being rewritten. For every read, the bench model records the expected colour before it applies that cycle's write, so each collision is checked against the value that should win.

// File: rtl/palPkg.sv
package palPkg;

  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chSel_t;

  // strobes handed from the sequencer to the datapath
  typedef struct packed {
    logic latchRed;
    logic latchGrn;
    logic commit;
  } palStrobe_t;

endpackage

// File: rtl/palCtrl.sv
module palCtrl
  import palPkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostAddrWr,
  input  logic             hostDataWr,
  input  logic [CH_W-1:0]  hostByte,
  output palStrobe_t       strb,
  output logic [IDX_W-1:0] wrIdx
);

  chSel_t chSel;

  always_comb begin
    strb = '0;
    if (!hostAddrWr && hostDataWr) begin
      unique case (chSel)
        CH_RED:  strb.latchRed = 1'b1;
        CH_GRN:  strb.latchGrn = 1'b1;
        default: strb.commit   = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chSel <= CH_RED;
      wrIdx <= '0;
    end else if (hostAddrWr) begin
      chSel <= CH_RED;
      wrIdx <= hostByte[IDX_W-1:0];
    end else if (hostDataWr) begin
      unique case (chSel)
        CH_RED: chSel <= CH_GRN;
        CH_GRN: chSel <= CH_BLU;
        default: begin
          chSel <= CH_RED;
          wrIdx <= wrIdx + 1'b1;
        end
      endcase
    end
  end

  AST_ADDR_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    hostAddrWr |=> (wrIdx == $past(hostByte[IDX_W-1:0])) && (chSel == CH_RED)); // R2

  AST_COMMIT_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (wrIdx == IDX_W'($past(wrIdx) + 1'b1)) && (chSel == CH_RED)); // R5

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R3

  AST_ADDR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    hostAddrWr |-> (strb == '0)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!hostAddrWr && !hostDataWr) |=> ($stable(wrIdx) && $stable(chSel))); // R9

endmodule

// File: rtl/palData.sv
module palData
  import palPkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  palStrobe_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [CH_W-1:0]   hostByte,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [3*CH_W-1:0] pixRgb
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int RGB_W = 3 * CH_W;

  logic [CH_W-1:0]  redHold;
  logic [CH_W-1:0]  grnHold;
  logic [RGB_W-1:0] table_q [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redHold <= '0;
      grnHold <= '0;
    end else begin
      if (strb.latchRed) redHold <= hostByte;
      if (strb.latchGrn) grnHold <= hostByte;
    end
  end

  // whole-entry commit on the blue byte
  always_ff @(posedge clk) begin
    if (strb.commit) table_q[wrIdx] <= {redHold, grnHold, hostByte};
  end

  // registered read; same-edge write is not visible (old data)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixRgb <= '0;
    else       pixRgb <= table_q[pixIdx];
  end

  AST_RED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchRed |=> $stable(redHold)); // R4

  AST_GRN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchGrn |=> $stable(grnHold)); // R4

endmodule

// File: rtl/palLut.sv
module palLut
  import palPkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostAddrWr,
  input  logic              hostDataWr,
  input  logic [CH_W-1:0]   hostByte,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [3*CH_W-1:0] pixRgb
);

  palStrobe_t       strb;
  logic [IDX_W-1:0] wrIdx;

  palCtrl #(.IDX_W(IDX_W), .CH_W(CH_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostAddrWr (hostAddrWr),
    .hostDataWr (hostDataWr),
    .hostByte   (hostByte),
    .strb       (strb),
    .wrIdx      (wrIdx)
  );

  palData #(.IDX_W(IDX_W), .CH_W(CH_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrIdx    (wrIdx),
    .hostByte (hostByte),
    .pixIdx   (pixIdx),
    .pixRgb   (pixRgb)
  );

  AST_RESET_OUT: assert property (@(posedge clk) !rstN |=> pixRgb == '0); // R1

endmodule

// File: tb/tb_palLut.sv
`timescale 1ns/1ps
module tb_palLut;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostAddrWr = 1'b0;
  logic        hostDataWr = 1'b0;
  logic [7:0]  hostByte = '0;
  logic [7:0]  pixIdx = '0;
  logic [23:0] pixRgb;

  int nChk = 0;
  int nFail = 0;
  bit doneRun = 0;

  logic [23:0] expTab [256];
  bit          known  [256];
  logic [7:0]  mIdx = '0;
  int          mSeq = 0;
  logic [7:0]  mR = '0, mG = '0;
  bit          pendKnown = 0;
  logic [23:0] pendVal = '0;
  string       pendTag = "";

  palLut dut (
    .clk(clk), .rstN(rstN), .hostAddrWr(hostAddrWr), .hostDataWr(hostDataWr),
    .hostByte(hostByte), .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

  always #4 clk = ~clk;

  task automatic check(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: pixRgb=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  // one cycle: check previous read, drive new inputs, advance the model
  task automatic step(bit aw, bit dw, logic [7:0] b, logic [7:0] p, string tag);
    @(negedge clk);
    if (pendKnown) check(pixRgb === pendVal, pendTag, pixRgb, pendVal);
    hostAddrWr = aw;
    hostDataWr = dw;
    hostByte   = b;
    pixIdx     = p;
    pendKnown  = known[p];
    pendVal    = expTab[p];
    pendTag    = tag;
    if (aw) begin
      mIdx = b;
      mSeq = 0;
    end else if (dw) begin
      case (mSeq)
        0: begin mR = b; mSeq = 1; end
        1: begin mG = b; mSeq = 2; end
        default: begin
          expTab[mIdx] = {mR, mG, b};
          known[mIdx]  = 1'b1;
          mIdx = mIdx + 8'd1;
          mSeq = 0;
        end
      endcase
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneRun) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog: run did not finish");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 256; i++) begin known[i] = 1'b0; expTab[i] = '0; end
    repeat (3) @(negedge clk);
    check(pixRgb === 24'h0, "R1 reset output", pixRgb, 24'h0);
    rstN = 1'b1;

    // R1/R3: stream the whole table from the reset index, no index write
    for (int i = 0; i < 256; i++) begin
      step(0, 1, 8'(i * 3),     8'($urandom), "R3");
      step(0, 1, 8'(i * 5 + 1), 8'($urandom), "R3");
      step(0, 1, 8'(i ^ 8'hA5), 8'($urandom), "R3");
    end
    for (int i = 0; i < 8; i++) step(0, 0, 8'h00, 8'(i), "R1");

    // R5: index wrapped to 0; R4: partial load leaves entry 0 intact
    step(0, 1, 8'hAA, 8'd0, "R4");
    step(0, 1, 8'hBB, 8'd0, "R4");
    step(0, 0, 8'h00, 8'd0, "R4");
    step(0, 0, 8'h00, 8'd0, "R4");

    // R2: index write abandons the partial entry, restarts at red
    step(1, 0, 8'd200, 8'd0, "R2");
    step(0, 1, 8'h11, 8'd200, "R2");
    step(0, 1, 8'h22, 8'd200, "R2");
    step(0, 1, 8'h33, 8'd200, "R2");
    step(0, 0, 8'h00, 8'd200, "R2");
    step(0, 0, 8'h00, 8'd0,   "R2");

    // R8: both strobes in one cycle
    step(1, 0, 8'd16, 8'd0, "R8");
    step(0, 1, 8'h44, 8'd0, "R8");
    step(1, 1, 8'd17, 8'd0, "R8");
    step(0, 1, 8'h55, 8'd17, "R8");
    step(0, 1, 8'h66, 8'd17, "R8");
    step(0, 1, 8'h77, 8'd17, "R8");
    step(0, 0, 8'h00, 8'd17, "R8");
    step(0, 0, 8'h00, 8'd16, "R8");

    // R7: commit and read of entry 40 in the same cycle
    step(1, 0, 8'd40, 8'd0, "R7");
    step(0, 1, 8'hC1, 8'd40, "R7");
    step(0, 1, 8'hC2, 8'd40, "R7");
    step(0, 1, 8'hC3, 8'd40, "R7");
    step(0, 0, 8'h00, 8'd40, "R7");
    step(0, 0, 8'h00, 8'd41, "R7");

    // R5: explicit wrap from 255 to 0
    step(1, 0, 8'd255, 8'd0, "R5");
    for (int i = 0; i < 6; i++) step(0, 1, 8'(8'hE0 + i), 8'd255, "R5");
    step(0, 0, 8'h00, 8'd255, "R5");
    step(0, 0, 8'h00, 8'd0,   "R5");

    // R9: idle cycles change nothing
    for (int i = 0; i < 16; i++) step(0, 0, 8'($urandom), 8'(i * 17), "R9");

    // R6: random mix, reads every cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 32;
      step(r == 0 || r == 31, (r >= 1 && r <= 20) || r == 31,
           8'($urandom), 8'($urandom), "R6");
    end
    step(0, 0, 8'h00, 8'd0, "R6");
    step(0, 0, 8'h00, 8'd0, "R6");
    doneRun = 1;
    report();
  end

endmodule